// File: doc/BRIEF.md
# Next-Line Prefetch Trigger Unit

This unit sits beside the request ports of a cache and watches incoming requests. When a cacheable read arrives and prefetching is switched on for its kind (instruction fetch or data load), the unit works out the address of the cache line that follows the requested one. It then issues a lookup for that line toward an external tag array. If the lookup reports a miss, the unit asks the next memory level to fetch and allocate the line. A lookup that hits ends the prefetch with no further traffic.

Two enable inputs gate the two request kinds independently, and both are expected to be held low after reset until software turns them on. The unit never lets a prefetch leave the 4 KB page of the triggering request. It keeps a single prefetch in flight. Any trigger that arrives while one is still in flight is discarded, not queued. The lookup handshake and the refill handshake each hold their request and address steady until the external side answers.

Top module: `nlPrefetchUnit`

## Requirements
- R1: After reset, neither `lkValid` nor `refillValid` is asserted.
- R2: An accepted instruction read (`reqIsInstr`=1) that is cacheable, with `instrPfEn`=1, raises `lkValid` on the clock edge that samples the request. `lkAddr` equals the request address with bits 4:0 cleared, plus 32.
- R3: An accepted data read (`reqIsInstr`=0) that is cacheable, with `dataPfEn`=1, starts a lookup at the next line in the same way. The two enables are independent.
- R4: A request whose kind has its enable at 0 starts no lookup, even when the other enable is 1.
- R5: A non-cacheable read (`reqCacheable`=0) or a write (`reqIsRead`=0) never starts a lookup.
- R6: No lookup starts when bits 31:12 of the next-line address differ from those of the request address, including the wrap past the top of the address space.
- R7: When `lkDone`=1 and `lkHit`=0, `refillValid` rises on the next edge with `refillAddr` equal to the looked-up address. It stays asserted until the cycle in which `refillReady`=1.
- R8: When `lkDone`=1 and `lkHit`=1, no refill request follows and the unit returns to idle.
- R9: While a lookup or refill is in flight, `lkAddr` stays stable and a new trigger is dropped. This includes a trigger presented in the same cycle as `lkDone` or `refillReady`, which never produces a later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | An incoming request is accepted this cycle |
| reqAddr | input | 32 | Byte address of the request |
| reqIsRead | input | 1 | 1 for a read, 0 for a write |
| reqCacheable | input | 1 | 1 when the request is cacheable |
| reqIsInstr | input | 1 | 1 for an instruction fetch, 0 for data |
| instrPfEn | input | 1 | Enables prefetch for instruction reads |
| dataPfEn | input | 1 | Enables prefetch for data reads |
| lkValid | output | 1 | Prefetch lookup request, held until `lkDone` |
| lkAddr | output | 32 | Line address to look up |
| lkDone | input | 1 | Lookup result is valid this cycle |
| lkHit | input | 1 | Lookup result: 1 hit, 0 miss |
| refillValid | output | 1 | Fetch-and-allocate request to next level |
| refillAddr | output | 32 | Line address to fetch |
| refillReady | input | 1 | Next level accepts the refill request |

## Verification
A new trigger can arrive in the same cycle that the tag array returns its lookup result. The unit is still busy on that edge, so the trigger must be dropped. The bench provokes this by waiting for the responder to raise `lkDone` and presenting a fresh prefetchable read before the next edge. The scoreboard then expects no lookup for that read: a lookup that appears later with no queued expectation counts as a failure. A follow-up read issued after the unit is idle must still be prefetched normally.

// File: rtl/nlpfPkg.sv
package nlpfPkg;

  typedef enum logic [1:0] {
    PF_IDLE   = 2'd0,
    PF_LOOKUP = 2'd1,
    PF_REFILL = 2'd2
  } pfState_e;

  typedef struct packed {
    logic loadAddr;   // capture next-line address of current request
    logic retire;     // prefetch finished, clear the held address
  } pfStrobes_t;

endpackage

// File: rtl/nlpfDatapath.sv
module nlpfDatapath
  import nlpfPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  pfStrobes_t        strobes,
  output logic              crossPage,
  output logic [ADDR_W-1:0] pfAddr
);

  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_INC  = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(LINE_INC - 1'b1);

  logic [ADDR_W-1:0] lineBase;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] addrQ;

  always_comb begin
    lineBase  = reqAddr & LINE_MASK;
    nextAddr  = lineBase + LINE_INC;
    crossPage = nextAddr[ADDR_W-1:PAGE_LSB] != reqAddr[ADDR_W-1:PAGE_LSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobes.loadAddr) begin
      addrQ <= nextAddr;
    end else if (strobes.retire) begin
      addrQ <= '0;
    end
  end

  assign pfAddr = addrQ;

  // R6: a captured prefetch address always lies in the page of its trigger
  p_same_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> pfAddr[ADDR_W-1:PAGE_LSB] == $past(reqAddr[ADDR_W-1:PAGE_LSB]))
    else $error("prefetch address left the trigger page");

  // R2: captured address is line aligned and strictly above the trigger
  p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> (pfAddr[LINE_LSB-1:0] == '0) && (pfAddr > $past(reqAddr)))
    else $error("prefetch address not the following line");

endmodule

// File: rtl/nlpfControl.sv
module nlpfControl
  import nlpfPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsRead,
  input  logic       reqCacheable,
  input  logic       reqIsInstr,
  input  logic       instrPfEn,
  input  logic       dataPfEn,
  input  logic       crossPage,
  input  logic       lkDone,
  input  logic       lkHit,
  input  logic       refillReady,
  output logic       lkValid,
  output logic       refillValid,
  output pfStrobes_t strobes
);

  pfState_e state, stateNext;
  logic kindEnabled;
  logic trigger;

  always_comb begin
    kindEnabled = reqIsInstr ? instrPfEn : dataPfEn;
    trigger     = reqValid && reqIsRead && reqCacheable && kindEnabled && !crossPage;
  end

  always_comb begin
    stateNext        = state;
    strobes.loadAddr = 1'b0;
    strobes.retire   = 1'b0;
    unique case (state)
      PF_IDLE: begin
        if (trigger) begin
          stateNext        = PF_LOOKUP;
          strobes.loadAddr = 1'b1;
        end
      end
      PF_LOOKUP: begin
        if (lkDone) begin
          if (lkHit) begin
            stateNext      = PF_IDLE;
            strobes.retire = 1'b1;
          end else begin
            stateNext = PF_REFILL;
          end
        end
      end
      PF_REFILL: begin
        if (refillReady) begin
          stateNext      = PF_IDLE;
          strobes.retire = 1'b1;
        end
      end
      default: stateNext = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PF_IDLE;
    else       state <= stateNext;
  end

  assign lkValid     = (state == PF_LOOKUP);
  assign refillValid = (state == PF_REFILL);

  // R5: writes and non-cacheable reads never start a lookup
  p_filter_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!lkValid && !refillValid && reqValid && (!reqIsRead || !reqCacheable)) |=> !lkValid)
    else $error("lookup from filtered request");

  // R4: a disabled request kind never starts a lookup
  p_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!lkValid && !refillValid && reqValid &&
     ((reqIsInstr && !instrPfEn) || (!reqIsInstr && !dataPfEn))) |=> !lkValid)
    else $error("lookup with kind disabled");

  // R8: a hit ends the prefetch without a refill
  p_hit_no_refill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkDone && lkHit) |=> (!refillValid && !lkValid))
    else $error("refill after hit");

  // R7: a miss leads to a refill request on the next edge
  p_miss_refill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkDone && !lkHit) |=> refillValid)
    else $error("no refill after miss");

  // R7: refill request held until accepted
  p_refill_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !refillReady) |=> refillValid)
    else $error("refill dropped before ready");

  // R9: a pending lookup is held until the result arrives
  p_lookup_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkDone) |=> lkValid)
    else $error("lookup dropped before done");

  // R9: never both handshakes at once
  p_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(lkValid && refillValid))
    else $error("lookup and refill together");

endmodule

// File: rtl/nlPrefetchUnit.sv
module nlPrefetchUnit
  import nlpfPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsRead,
  input  logic              reqCacheable,
  input  logic              reqIsInstr,
  input  logic              instrPfEn,
  input  logic              dataPfEn,
  output logic              lkValid,
  output logic [ADDR_W-1:0] lkAddr,
  input  logic              lkDone,
  input  logic              lkHit,
  output logic              refillValid,
  output logic [ADDR_W-1:0] refillAddr,
  input  logic              refillReady
);

  pfStrobes_t        strobes;
  logic              crossPage;
  logic [ADDR_W-1:0] pfAddr;

  nlpfControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqIsRead    (reqIsRead),
    .reqCacheable (reqCacheable),
    .reqIsInstr   (reqIsInstr),
    .instrPfEn    (instrPfEn),
    .dataPfEn     (dataPfEn),
    .crossPage    (crossPage),
    .lkDone       (lkDone),
    .lkHit        (lkHit),
    .refillReady  (refillReady),
    .lkValid      (lkValid),
    .refillValid  (refillValid),
    .strobes      (strobes)
  );

  nlpfDatapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .strobes   (strobes),
    .crossPage (crossPage),
    .pfAddr    (pfAddr)
  );

  assign lkAddr     = pfAddr;
  assign refillAddr = pfAddr;

  // R9: address presented to the tag array stays put while waiting
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkDone) |=> $stable(lkAddr))
    else $error("lookup address moved");

  // R7: refill targets the line that was looked up
  p_refill_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkDone && !lkHit) |=> refillAddr == $past(lkAddr))
    else $error("refill address differs from lookup");

endmodule

// File: tb/sim_nlPrefetchUnit.sv
`timescale 1ns/1ps
module sim_nlPrefetchUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsRead = 1'b0, reqCacheable = 1'b0, reqIsInstr = 1'b0;
  logic        instrPfEn = 1'b0, dataPfEn = 1'b0;
  logic        lkValid, refillValid;
  logic [31:0] lkAddr, refillAddr;
  logic        lkDone = 1'b0, lkHit = 1'b0, refillReady = 1'b0;

  int          nTests = 0;
  int          nFail  = 0;
  int          cycles = 0;
  logic        respHit = 1'b1;
  int          lkWait = 0;
  logic        lkPrev = 1'b0, rfPrev = 1'b0;
  logic [31:0] expLk[$];
  logic [31:0] expRf[$];

  always #10 clk = ~clk;   // 50 MHz

  nlPrefetchUnit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsRead(reqIsRead), .reqCacheable(reqCacheable), .reqIsInstr(reqIsInstr),
    .instrPfEn(instrPfEn), .dataPfEn(dataPfEn), .lkValid(lkValid), .lkAddr(lkAddr),
    .lkDone(lkDone), .lkHit(lkHit), .refillValid(refillValid),
    .refillAddr(refillAddr), .refillReady(refillReady)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one request cycle; expectation from the bench's own model
  task automatic issue(input logic [31:0] a, input bit rd, input bit cch,
                       input bit ins, input bit willPush, input bit miss);
    logic [31:0] nxt;
    nxt = (a & ~32'h1F) + 32'd32;
    if (willPush && rd && cch && (ins ? instrPfEn : dataPfEn) && (nxt[31:12] == a[31:12])) begin
      expLk.push_back(nxt);
      if (miss) expRf.push_back(nxt);
    end
    respHit      = !miss;
    reqAddr      = a;
    reqIsRead    = rd;
    reqCacheable = cch;
    reqIsInstr   = ins;
    reqValid     = 1'b1;
    @(negedge clk);
    reqValid     = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (8) @(negedge clk);
    check(expLk.size() == 0, {req, " lookups outstanding"}, expLk.size(), 0);
    check(expRf.size() == 0, {req, " refills outstanding"}, expRf.size(), 0);
    check(!lkValid && !refillValid, {req, " idle"}, {lkValid, refillValid}, 0);
  endtask

  // Monitor and tag/next-level responder
  always @(negedge clk) begin
    if (rstN) begin
      if (lkValid && !lkPrev) begin
        if (expLk.size() == 0) check(1'b0, "R9 unexpected lookup", lkAddr, 0);
        else begin
          logic [31:0] e;
          e = expLk.pop_front();
          check(lkAddr == e, "R2/R3 lookup address", lkAddr, e);
        end
      end
      if (refillValid && !rfPrev) begin
        if (expRf.size() == 0) check(1'b0, "R8 unexpected refill", refillAddr, 0);
        else begin
          logic [31:0] e;
          e = expRf.pop_front();
          check(refillAddr == e, "R7 refill address", refillAddr, e);
        end
      end
      lkPrev = lkValid;
      rfPrev = refillValid;
      if (lkDone) lkDone = 1'b0;
      else if (lkValid) begin
        if (lkWait == 1) begin
          lkDone = 1'b1; lkHit = respHit; lkWait = 0;
        end else lkWait++;
      end
      if (refillReady) refillReady = 1'b0;
      else if (refillValid) refillReady = 1'b1;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nTests++; nFail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!lkValid, "R1 lkValid at reset", lkValid, 0);
    check(!refillValid, "R1 refillValid at reset", refillValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!lkValid && !refillValid, "R1 idle after reset", {lkValid, refillValid}, 0);

    // R2: instruction read, hit
    instrPfEn = 1'b1;
    issue(32'h1000_0044, 1, 1, 1, 1, 0);
    settle("R2");

    // R3: data read, miss, refill
    instrPfEn = 1'b0; dataPfEn = 1'b1;
    issue(32'h2000_0100, 1, 1, 0, 1, 1);
    settle("R3 R7");

    // R4: kinds gated separately
    issue(32'h2000_0200, 1, 1, 1, 1, 0);
    settle("R4 instr off");
    instrPfEn = 1'b1; dataPfEn = 1'b0;
    issue(32'h2000_0300, 1, 1, 0, 1, 0);
    settle("R4 data off");
    dataPfEn = 1'b1;

    // R5: writes and non-cacheable reads
    issue(32'h4000_0000, 1, 0, 0, 1, 0);
    issue(32'h4000_0040, 0, 1, 1, 1, 0);
    settle("R5");

    // R6: page boundary and top-of-space wrap
    issue(32'h3000_0FE4, 1, 1, 0, 1, 0);
    issue(32'hFFFF_FFF0, 1, 1, 1, 1, 0);
    settle("R6 cross");
    issue(32'h3000_0FC0, 1, 1, 0, 1, 1);
    settle("R6 last line in page");

    // R9: trigger during lookup dropped
    issue(32'h5000_0000, 1, 1, 1, 1, 0);
    issue(32'h5000_0400, 1, 1, 1, 0, 0);
    settle("R9 busy drop");

    // R9: trigger in same cycle as lkDone dropped
    issue(32'h6000_0000, 1, 1, 0, 1, 0);
    @(posedge lkDone);
    reqAddr = 32'h6000_0800; reqIsRead = 1; reqCacheable = 1; reqIsInstr = 0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    settle("R9 same cycle as done");

    // R8 then R2: hit returns to idle and a follow-up is served
    issue(32'h7000_0020, 1, 1, 1, 1, 0);
    settle("R8 hit idle");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule